// File: doc/BRIEF.md
# Three-Wire Temperature Sensor Slave Port

This block is the slave end of a three-wire serial link. The link has an active-low select, a serial clock that the master drives, and one data line. The data line is split into separate input, output and output-enable pins at the block edge. The block sits in front of a small register file. The temperature word arrives on a parallel input. When select falls, that word is frozen into a shadow copy. The first sixteen serial clocks then shift the copy out, most significant bit first. After that the line turns around to input, and the master sends a command byte. The command picks a read or a write and names one of four registers. A sixteen-bit data phase follows. Command and data pairs can repeat for as long as select stays low.

All three link pins are resynchronised into the system clock domain. Serial clock edges are then detected as one-cycle pulses, and the slave logic runs entirely on the system clock. Output bits change on serial clock falling edges and input bits are taken on rising edges. Raising select ends whatever is in progress. Write data is committed one byte at a time, so an early release leaves a defined partial result.

Top module: `sio_sensor_slave`

## Requirements
- R1: After reset, `sio_oe` and `sio_out` are both low.
- R2: On a falling `cs_n` the value on `temp_in` is captured. The next 16 serial clocks present it on `sio_out`, most significant bit first, valid at each rising `sclk`. Changes on `temp_in` during the readout do not alter the shifted word.
- R3: `sio_oe` is high only during the temperature readout and during read data phases. It is low while command bits and write data bits are clocked in.
- R4: Command byte encoding: bit 7 = 1 selects read and 0 selects write. Bits 1:0 select the register: 0 = control (8-bit), 1 = upper limit, 2 = lower limit, 3 = identity. Bits 6:2 have no effect.
- R5: A read data phase shifts 16 bits out, most significant bit first. The control register reads zero-extended in bits 15:8.
- R6: The identity register always reads `ID_VALUE` (default 16'h5A17). Writes to it leave it unchanged.
- R7: A complete 16-bit write updates both bytes of a limit register. For the control register, data bits 7:0 are stored when the 16th bit arrives.
- R8: If `cs_n` rises after the 8th data bit of a limit write but before the 16th, only the upper byte changes.
- R9: If `cs_n` rises before the 8th command bit or before the 8th data bit, no register changes.
- R10: Any number of command and data pairs may follow one temperature readout within a single select assertion.
- R11: A rising `cs_n` ends the transfer at once, including a partial temperature readout. `sio_oe` drops, and the next select begins again with a fresh temperature readout.
- R12: When the `sclk` rising edge that completes a data byte and the `cs_n` rising edge are seen in the same cycle, the byte is still committed.
- R13: Reset values are: control 8'h00, upper limit `HI_RST` (default 16'h2800), lower limit `LO_RST` (default 16'h0500).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial clock from the master, idle low |
| sio_in | input | 1 | Data line as seen from the pad |
| temp_in | input | 16 | Current temperature word |
| sio_out | output | 1 | Data value driven toward the pad |
| sio_oe | output | 1 | Drive enable for the data line |

## Verification
Two functions can land in the same system-clock cycle. One is the byte-completing sample of a write, which commits data. The other is the release of select, which aborts the transfer. The bench provokes this by raising `sclk` and `cs_n` in the same time step on the 8th data bit of a limit write. Both pass through synchronisers of equal depth, so both pulses reach the slave logic together. The bench then reads the register back in a later transfer and expects the upper byte to be updated (R12), while the lower byte stays as it was.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TEMP,
        PH_CMD,
        PH_RD,
        PH_WR
    } phase_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 2'd0,
        RA_HIGH = 2'd1,
        RA_LOW  = 2'd2,
        RA_ID   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       rd;
        logic [4:0] spare;
        reg_addr_e  addr;
    } cmd_t;

    typedef struct packed {
        logic              hi;
        logic              lo;
        reg_addr_e         addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic drives_line(phase_e p);
        return (p == PH_TEMP) || (p == PH_RD);
    endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int                STAGES  = 2,
    parameter int                WIDTH   = 3,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_VALUE = 16'h5A17,
    parameter logic [WORD_W-1:0] HI_RST   = 16'h2800,
    parameter logic [WORD_W-1:0] LO_RST   = 16'h0500
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  reg_addr_e         rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int N_LIM = 2;

    logic [BYTE_W-1:0] ctrl_q;
    logic [WORD_W-1:0] lim_word [N_LIM];

    always_ff @(posedge clk) begin
        if (rst)                              ctrl_q <= '0;
        else if (wr.lo && wr.addr == RA_CTRL) ctrl_q <= wr.data;
    end

    for (genvar g = 0; g < N_LIM; g++) begin : g_lim
        localparam logic [WORD_W-1:0] RV = (g == 0) ? HI_RST : LO_RST;
        localparam reg_addr_e         MY = reg_addr_e'(g + 1);
        logic [WORD_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RV;
            end else begin
                if (wr.hi && wr.addr == MY) q[WORD_W-1:BYTE_W] <= wr.data;
                if (wr.lo && wr.addr == MY) q[BYTE_W-1:0]      <= wr.data;
            end
        end
        assign lim_word[g] = q;
    end

    always_comb begin
        unique case (rd_addr)
            RA_CTRL: rd_data = {{(WORD_W-BYTE_W){1'b0}}, ctrl_q};
            RA_HIGH: rd_data = lim_word[0];
            RA_LOW:  rd_data = lim_word[1];
            default: rd_data = ID_VALUE;
        endcase
    end
endmodule

// File: rtl/sio_engine.sv
module sio_engine
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              din,
    input  logic [WORD_W-1:0] temp,
    input  logic [WORD_W-1:0] rd_data,
    output reg_addr_e         rd_addr,
    output wr_req_t           wr,
    output logic              dout,
    output logic              oe
);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);

    phase_e            ph;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sh;
    cmd_t              cmd_q;
    logic [BYTE_W-1:0] byte_in;
    cmd_t              cmd_nxt;

    assign byte_in = {sh[BYTE_W-2:0], din};
    assign cmd_nxt = cmd_t'(byte_in);
    assign rd_addr = cmd_nxt.addr;

    assign wr.hi   = sck_rise && ph == PH_WR && cnt == BYTE_LAST;
    assign wr.lo   = sck_rise && ph == PH_WR && cnt == LAST_BIT;
    assign wr.addr = cmd_q.addr;
    assign wr.data = byte_in;

    assign oe   = drives_line(ph);
    assign dout = oe & sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            sh    <= '0;
            cmd_q <= '0;
        end else begin
            if (cs_fall) begin
                ph  <= PH_TEMP;
                cnt <= '0;
                sh  <= temp;
            end else if (ph != PH_IDLE) begin
                if (sck_rise) begin
                    cnt <= cnt + 1'b1;
                    unique case (ph)
                        PH_TEMP: if (cnt == LAST_BIT) ph <= PH_CMD;
                        PH_CMD: begin
                            sh <= {sh[WORD_W-2:0], din};
                            if (cnt == BYTE_LAST) begin
                                cmd_q <= cmd_nxt;
                                cnt   <= '0;
                                if (cmd_nxt.rd) begin
                                    ph <= PH_RD;
                                    sh <= rd_data;
                                end else begin
                                    ph <= PH_WR;
                                end
                            end
                        end
                        PH_RD: if (cnt == LAST_BIT) ph <= PH_CMD;
                        PH_WR: begin
                            sh <= {sh[WORD_W-2:0], din};
                            if (cnt == LAST_BIT) ph <= PH_CMD;
                        end
                        default: ;
                    endcase
                end else if (sck_fall && drives_line(ph) && cnt != '0) begin
                    sh <= {sh[WORD_W-2:0], 1'b0};
                end
            end
            if (cs_rise) ph <= PH_IDLE;
        end
    end
endmodule

// File: rtl/sio_sensor_slave.sv
module sio_sensor_slave
    import sio_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] ID_VALUE    = 16'h5A17,
    parameter logic [WORD_W-1:0] HI_RST      = 16'h2800,
    parameter logic [WORD_W-1:0] LO_RST      = 16'h0500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sio_in,
    input  logic [WORD_W-1:0] temp_in,
    output logic              sio_out,
    output logic              sio_oe
);
    logic [2:0]        pin_lvl, pin_rise, pin_fall;
    logic              cs_fall, cs_rise, sck_rise, sck_fall, din_s;
    reg_addr_e         rd_addr;
    logic [WORD_W-1:0] rd_data;
    wr_req_t           wr_req;

    sio_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({cs_n, sclk, sio_in}),
        .lvl (pin_lvl),
        .rise(pin_rise),
        .fall(pin_fall)
    );

    assign cs_fall  = pin_fall[2];
    assign cs_rise  = pin_rise[2];
    assign sck_rise = pin_rise[1];
    assign sck_fall = pin_fall[1];
    assign din_s    = pin_lvl[0];

    sio_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .cs_fall (cs_fall),
        .cs_rise (cs_rise),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .din     (din_s),
        .temp    (temp_in),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr      (wr_req),
        .dout    (sio_out),
        .oe      (sio_oe)
    );

    sio_regfile #(
        .ID_VALUE(ID_VALUE),
        .HI_RST  (HI_RST),
        .LO_RST  (LO_RST)
    ) u_rf (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_req),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/sio_sensor_slave_chk.sv
module sio_sensor_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        sio_oe,
    input logic        sio_out,
    input logic        cs_fall,
    input logic        cs_rise,
    input logic        sck_rise,
    input logic        sck_fall,
    input logic        wr_hi,
    input logic        wr_lo,
    input logic [1:0]  rd_addr,
    input logic [15:0] rd_data
);
    AST_OUT_STEADY: assert property (@(posedge clk) disable iff (rst)
        (sio_oe && $past(sio_oe) && !$past(sck_fall) && !$past(sck_rise) && !$past(cs_fall)) |-> $stable(sio_out)); // R2

    AST_OE_START: assert property (@(posedge clk) disable iff (rst)
        $rose(sio_oe) |-> ($past(cs_fall) || $past(sck_rise))); // R3

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!wr_hi && !wr_lo) |=> (!$stable(rd_addr) || $stable(rd_data))); // R9

    AST_UPPER_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo) |=> (!$stable(rd_addr) || rd_data[7:0] == $past(rd_data[7:0]))); // R8

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> !sio_oe); // R11
endmodule

bind sio_sensor_slave sio_sensor_slave_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sio_oe  (sio_oe),
    .sio_out (sio_out),
    .cs_fall (cs_fall),
    .cs_rise (cs_rise),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .wr_hi   (wr_req.hi),
    .wr_lo   (wr_req.lo),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/tb_sio_sensor_slave.sv
module tb_sio_sensor_slave;
    localparam int HALF = 8;
    localparam logic [15:0] ID_V = 16'h5A17;
    localparam logic [15:0] HI_R = 16'h2800;
    localparam logic [15:0] LO_R = 16'h0500;

    logic clk = 0, rst = 1, cs_n = 1, sclk = 0, sio_in = 0;
    logic [15:0] temp_in = '0;
    logic sio_out, sio_oe;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0]  ctrl_m = 8'h00;
    logic [15:0] hi_m = HI_R, lo_m = LO_R;

    always #2.5 clk = ~clk;

    sio_sensor_slave dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sio_in(sio_in),
        .temp_in(temp_in), .sio_out(sio_out), .sio_oe(sio_oe)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 0;
        wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        cs_n = 1;
        wait_clk(2 * HALF);
    endtask

    task automatic clk_bit(input logic b, output logic o, output logic oe_s);
        sio_in = b;
        wait_clk(HALF);
        o = sio_out;
        oe_s = sio_oe;
        sclk = 1;
        wait_clk(HALF);
        sclk = 0;
    endtask

    task automatic read_word(output logic [15:0] v, output logic oe_all);
        logic o, e;
        v = '0;
        oe_all = 1;
        for (int i = 0; i < 16; i++) begin
            clk_bit(1'b0, o, e);
            v = {v[14:0], o};
            oe_all &= e;
        end
    endtask

    // R2: temp_in is flipped mid-readout; the frozen copy must come out.
    task automatic read_temp(logic [15:0] exp);
        logic o, e, oe_all;
        logic [15:0] v = '0;
        oe_all = 1;
        for (int i = 0; i < 16; i++) begin
            if (i == 8) temp_in = ~temp_in;
            clk_bit(1'b0, o, e);
            v = {v[14:0], o};
            oe_all &= e;
        end
        check("R2 temperature word", v, exp);
        check("R3 oe during readout", 16'(oe_all), 16'h1);
    endtask

    task automatic send_byte(logic [7:0] b);
        logic o, e, oe_any;
        oe_any = 0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], o, e);
            oe_any |= e;
        end
        check("R3 oe low during command", 16'(oe_any), 16'h0);
    endtask

    task automatic send_data(logic [15:0] d, int nbits, bit tie);
        logic o, e, oe_any;
        oe_any = 0;
        for (int i = 0; i < nbits; i++) begin
            if (tie && i == nbits - 1) begin
                sio_in = d[15 - i];
                wait_clk(HALF);
                sclk = 1;
                cs_n = 1;
                wait_clk(HALF);
                sclk = 0;
                wait_clk(2 * HALF);
            end else begin
                clk_bit(d[15 - i], o, e);
                oe_any |= e;
            end
        end
        check("R3 oe low during write data", 16'(oe_any), 16'h0);
    endtask

    function automatic logic [15:0] exp_read(logic [1:0] a);
        case (a)
            2'd0: return {8'h00, ctrl_m};
            2'd1: return hi_m;
            2'd2: return lo_m;
            default: return ID_V;
        endcase
    endfunction

    function automatic void apply_write(logic [1:0] a, logic [15:0] d, int nbits);
        if (nbits >= 8) begin
            if (a == 2'd1) hi_m[15:8] = d[15:8];
            if (a == 2'd2) lo_m[15:8] = d[15:8];
        end
        if (nbits >= 16) begin
            if (a == 2'd0) ctrl_m = d[7:0];
            if (a == 2'd1) hi_m[7:0] = d[7:0];
            if (a == 2'd2) lo_m[7:0] = d[7:0];
        end
    endfunction

    function automatic logic [7:0] mk_cmd(bit rd, logic [1:0] a);
        logic [4:0] junk = 5'($urandom);
        return {rd, junk, a};
    endfunction

    task automatic start_txn();
        logic [15:0] t = 16'($urandom);
        temp_in = t;
        cs_begin();
        read_temp(t);
    endtask

    task automatic txn_write(logic [1:0] a, logic [15:0] d, int nbits, bit tie);
        start_txn();
        send_byte(mk_cmd(1'b0, a));
        send_data(d, nbits, tie);
        if (!tie) cs_end();
        apply_write(a, d, nbits);
    endtask

    task automatic txn_read(logic [1:0] a, string req);
        logic [15:0] v;
        logic oe_all;
        start_txn();
        send_byte(mk_cmd(1'b1, a));
        read_word(v, oe_all);
        check({req, " readback"}, v, exp_read(a));
        check("R5 oe during read data", 16'(oe_all), 16'h1);
        cs_end();
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic o, e;
        logic [15:0] v;
        logic oe_all;
        void'($urandom(32'h5EED_0042));
        wait_clk(6);
        rst = 0;
        wait_clk(2);
        check("R1 oe after reset", 16'(sio_oe), 16'h0);
        check("R1 out after reset", 16'(sio_out), 16'h0);

        // R13 reset values
        txn_read(2'd0, "R13 control");
        txn_read(2'd1, "R13 upper limit");
        txn_read(2'd2, "R13 lower limit");

        // R6 identity constant and write ignored
        txn_read(2'd3, "R6 identity");
        txn_write(2'd3, 16'h1234, 16, 0);
        txn_read(2'd3, "R6 identity after write");

        // R7 full writes, R4 ignored bits, R5 zero extension
        txn_write(2'd1, 16'hBEEF, 16, 0);
        txn_read(2'd1, "R7 upper full");
        txn_write(2'd0, 16'hA5C3, 16, 0);
        txn_read(2'd0, "R5 R4 control zero-extended");

        // R8 partial write keeps low byte
        txn_write(2'd2, 16'h7E11, 12, 0);
        txn_read(2'd2, "R8 lower partial");

        // R9 short data phase leaves register alone
        txn_write(2'd1, 16'h0000, 5, 0);
        txn_read(2'd1, "R9 short data");

        // R9 command cut before 8th bit
        start_txn();
        for (int i = 0; i < 5; i++) clk_bit(1'b0, o, e);
        cs_end();
        txn_read(2'd1, "R9 short command");

        // R11 abort during temperature readout
        temp_in = 16'hFFFF;
        cs_begin();
        for (int i = 0; i < 5; i++) clk_bit(1'b0, o, e);
        cs_end();
        check("R11 oe after abort", 16'(sio_oe), 16'h0);
        txn_read(2'd3, "R11 fresh transfer");

        // R12 byte-completing edge coincident with select release
        txn_write(2'd2, 16'hC3FF, 8, 1);
        txn_read(2'd2, "R12 tie commit");

        // R10 repeated pairs in one select
        start_txn();
        send_byte(mk_cmd(1'b0, 2'd1));
        send_data(16'h1357, 16, 0);
        apply_write(2'd1, 16'h1357, 16);
        send_byte(mk_cmd(1'b1, 2'd1));
        read_word(v, oe_all);
        check("R10 pair 2 upper", v, exp_read(2'd1));
        send_byte(mk_cmd(1'b0, 2'd2));
        send_data(16'h2468, 16, 0);
        apply_write(2'd2, 16'h2468, 16);
        send_byte(mk_cmd(1'b1, 2'd2));
        read_word(v, oe_all);
        check("R10 pair 4 lower", v, exp_read(2'd2));
        send_byte(mk_cmd(1'b1, 2'd3));
        read_word(v, oe_all);
        check("R10 pair 5 identity", v, ID_V);
        cs_end();

        // random mix
        for (int k = 0; k < 16; k++) begin
            logic [1:0] a = 2'($urandom);
            logic [15:0] d = 16'($urandom);
            int nb;
            case ($urandom % 4)
                0: nb = 3;
                1: nb = 8;
                2: nb = 12;
                default: nb = 16;
            endcase
            txn_write(a, d, nb, 0);
            txn_read(a, "R7 R8 R9 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule